// File: doc/BRIEF.md
# Retirement Tag-Matching Event Counter

This block counts operations at the point where they retire, using tags placed on them earlier in the pipeline. An upstream stamping stage puts a programmed 4-bit tag value on every operation that hits a monitored event. Operations of the replay class get that tag only while a dedicated tagging enable is set. At retirement, a 4-bit selection mask picks which tag bits may count. An operation that retires on the correct path and has at least one tag bit inside the mask adds one to a 40-bit counter. Because there are four separate bits, up to four events can be tracked at once. They can be counted one at a time or together, by stamping several bits upstream or by opening several mask bits downstream.

The counter can be preset through a load port, so that it wraps after a chosen number of events. On the wrap it raises a one-cycle overflow pulse. When precise sampling is enabled, a sample-request pulse is raised together with it.

Top module: `tagret_counter`

## Requirements
- R1: While reset is asserted, and right after it, the count is zero, overflow and sample request are low, and the control register is cleared, so the stamping output is zero.
- R2: The control word written with cfg_we holds the tag value in bits [3:0], the retirement mask in bits [11:8], the replay tagging enable in bit 24 and the precise sampling enable in bit 25. It takes effect from the cycle after the write.
- R3: up_tag combinationally equals the programmed tag value when up_valid and up_hit are high and the operation is not of the replay class, and equals 0 when up_valid or up_hit is low.
- R4: A replay-class operation (up_replay high) gets the tag value only while bit 24 is set, and otherwise gets tag 0.
- R5: With bits 24 and 25 both clear, non-replay operations are still stamped and their tags still count, giving ordinary non-precise counting.
- R6: When rt_valid and rt_good are high and rt_tag AND mask is nonzero, the count rises by one at the next clock edge.
- R7: A retiring operation with rt_good low, or with rt_valid low, never changes the count.
- R8: The count rises by at most one per cycle, even when several tag bits match the mask.
- R9: With tag value 3 and mask 0011, operations tagged 0001 or 0010 are counted, and operations tagged 0100 are not.
- R10: cnt_ld loads cnt_ld_val at the next edge and takes priority over an increment in the same cycle.
- R11: An increment from all-ones wraps the count to zero, and ovf is high for exactly the one cycle in which the count reads zero.
- R12: sample_req pulses with ovf only when bit 25 was set at the time of the wrap, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control word |
| up_valid | input | 1 | Upstream operation valid |
| up_hit | input | 1 | Upstream operation hits the monitored event |
| up_replay | input | 1 | Upstream operation belongs to the replay class |
| up_tag | output | 4 | Tag stamped on the upstream operation |
| rt_valid | input | 1 | Retiring operation valid |
| rt_good | input | 1 | Retiring operation is on the correct path |
| rt_tag | input | 4 | Tag carried by the retiring operation |
| cnt_ld | input | 1 | Counter preset strobe |
| cnt_ld_val | input | 40 | Counter preset value |
| count | output | 40 | Current event count |
| ovf | output | 1 | One-cycle wrap pulse |
| sample_req | output | 1 | Precise sampling request pulse |

## Verification
The bench aims at several matching tags on a single retiring operation. A design that added the number of matching bits would jump the count by more than one. It drives bad-path retirements with matching tags, which a design that ignores the good flag would count. It toggles the replay enable with replay-class hits, where a broken gate would stamp tags that should be zero. It also presets the counter just below all-ones, with precise sampling both on and off. This catches a missed wrap, an overflow pulse that lasts too long or comes a cycle late, and a sample request that does not depend on bit 25. A load issued together with an increment is also checked, to confirm that the load wins.

// File: rtl/tagret_pkg.sv
package tagret_pkg;
  localparam int TAG_W      = 4;
  localparam int CFG_W      = 32;
  localparam int TAG_LSB    = 0;
  localparam int MASK_LSB   = 8;
  localparam int TAGEN_BIT  = 24;
  localparam int PRECISE_BIT = 25;

  typedef struct packed {
    logic             precise;
    logic             tag_en;
    logic [TAG_W-1:0] mask;
    logic [TAG_W-1:0] tag_val;
  } ctl_t;

  function automatic ctl_t unpack_ctl(input logic [CFG_W-1:0] w);
    ctl_t c;
    c.tag_val = w[TAG_LSB +: TAG_W];
    c.mask    = w[MASK_LSB +: TAG_W];
    c.tag_en  = w[TAGEN_BIT];
    c.precise = w[PRECISE_BIT];
    return c;
  endfunction
endpackage

// File: rtl/tag_stamp.sv
module tag_stamp
  import tagret_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             hit,
  input  logic             replay,
  input  logic             tag_en,
  input  logic [TAG_W-1:0] tag_val,
  output logic [TAG_W-1:0] tag
);
  logic allow;

  always_comb begin
    allow = valid & hit & (~replay | tag_en);
    tag   = allow ? tag_val : '0;
  end

  // R4: replay-class operations stay untagged while tagging is disabled
  assert_replay_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (replay && !tag_en) |-> (tag == '0));
  // R3: operations without a hit carry no tag
  assert_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid || !hit) |-> (tag == '0));
endmodule

// File: rtl/retire_match.sv
module retire_match
  import tagret_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             good,
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] mask,
  output logic             inc
);
  logic [TAG_W-1:0] sel;

  always_comb begin
    sel = tag & mask;
    inc = valid & good & (|sel);
  end

  // R7: a bad-path retirement never requests an increment
  assert_bad_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!good || !valid) |-> !inc);
  // R6: an empty tag never requests an increment
  assert_empty_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag == '0) |-> !inc);
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             precise,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             sample
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, wrap;
  logic             ovf_q, smp_q;

  always_comb begin
    sum    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    cnt_en = ld | inc;
    cnt_d  = cnt_q;
    wrap   = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
    end else if (inc) begin
      cnt_d = sum[CNT_W-1:0];
      wrap  = sum[CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      smp_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ovf_q <= wrap;
      smp_q <= wrap & precise;
    end
  end

  assign count  = cnt_q;
  assign ovf    = ovf_q;
  assign sample = smp_q;

  // R11: the wrap pulse coincides with a zero count
  assert_wrap_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0));
  // R8: one increment moves the count by exactly one
  assert_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> (count == $past(count) + 1'b1));
  // R7: without increment or load the count holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(count));
  // R10: a load wins over an increment
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (count == $past(ld_val)));
  // R11: overflow is a single-cycle pulse
  assert_ovf_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);
endmodule

// File: rtl/tagret_counter.sv
module tagret_counter
  import tagret_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic             up_valid,
  input  logic             up_hit,
  input  logic             up_replay,
  output logic [3:0]       up_tag,
  input  logic             rt_valid,
  input  logic             rt_good,
  input  logic [3:0]       rt_tag,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt_ld_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             sample_req
);
  ctl_t ctl_q, ctl_d;
  logic inc;

  always_comb begin
    ctl_d = cfg_we ? unpack_ctl(cfg_wdata) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  tag_stamp u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (up_valid),
    .hit     (up_hit),
    .replay  (up_replay),
    .tag_en  (ctl_q.tag_en),
    .tag_val (ctl_q.tag_val),
    .tag     (up_tag)
  );

  retire_match u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (rt_valid),
    .good  (rt_good),
    .tag   (rt_tag),
    .mask  (ctl_q.mask),
    .inc   (inc)
  );

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc),
    .ld      (cnt_ld),
    .ld_val  (cnt_ld_val),
    .precise (ctl_q.precise),
    .count   (count),
    .ovf     (ovf),
    .sample  (sample_req)
  );

  // R12: a sample request never appears without an overflow
  assert_sample_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> ovf);
endmodule

// File: tb/tagret_counter_test.sv
module tagret_counter_test;
  localparam int W = 40;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [31:0]   cfg_wdata;
  logic          up_valid, up_hit, up_replay;
  logic [3:0]    up_tag;
  logic          rt_valid, rt_good;
  logic [3:0]    rt_tag;
  logic          cnt_ld;
  logic [W-1:0]  cnt_ld_val;
  logic [W-1:0]  count;
  logic          ovf, sample_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0]   m_tag, m_mask;
  logic         m_ten, m_prec;
  logic [W-1:0] m_cnt;
  logic         m_ovf, m_smp;

  always #2 clk = ~clk;

  tagret_counter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .up_valid(up_valid), .up_hit(up_hit), .up_replay(up_replay), .up_tag(up_tag),
    .rt_valid(rt_valid), .rt_good(rt_good), .rt_tag(rt_tag),
    .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val),
    .count(count), .ovf(ovf), .sample_req(sample_req)
  );

  function automatic logic [31:0] mkcfg(logic [3:0] t, logic [3:0] m, logic te, logic pr);
    logic [31:0] w = '0;
    w[3:0] = t; w[11:8] = m; w[24] = te; w[25] = pr;
    return w;
  endfunction

  function automatic logic [3:0] exp_tag();
    if (up_valid && up_hit && (!up_replay || m_ten)) return m_tag;
    return 4'h0;
  endfunction

  function automatic logic exp_inc();
    return rt_valid && rt_good && ((rt_tag & m_mask) != 4'h0);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_wdata = '0; up_valid = 0; up_hit = 0; up_replay = 0;
    rt_valid = 0; rt_good = 0; rt_tag = '0; cnt_ld = 0; cnt_ld_val = '0;
  endtask

  // one clock: inputs already driven after a negedge; advance model and compare
  task automatic step(string req);
    logic [W:0] s;
    #1;
    chk({req, " up_tag"}, {36'd0, up_tag}, {36'd0, exp_tag()});
    m_ovf = 0; m_smp = 0;
    if (cnt_ld) m_cnt = cnt_ld_val;
    else if (exp_inc()) begin
      s = {1'b0, m_cnt} + 1'b1;
      m_cnt = s[W-1:0];
      m_ovf = s[W];
      m_smp = s[W] & m_prec;
    end
    if (cfg_we) begin
      m_tag = cfg_wdata[3:0]; m_mask = cfg_wdata[11:8];
      m_ten = cfg_wdata[24]; m_prec = cfg_wdata[25];
    end
    @(posedge clk); #1;
    chk({req, " count"}, count, m_cnt);
    chk({req, " ovf"}, {39'd0, ovf}, {39'd0, m_ovf});
    chk({req, " sample_req"}, {39'd0, sample_req}, {39'd0, m_smp});
    @(negedge clk);
    idle();
  endtask

  task automatic wcfg(logic [31:0] w);
    cfg_we = 1; cfg_wdata = w; step("R2 cfg write");
  endtask

  task automatic retire(logic g, logic [3:0] t, string req);
    rt_valid = 1; rt_good = g; rt_tag = t; step(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    rst_n = 0;
    m_tag = 0; m_mask = 0; m_ten = 0; m_prec = 0; m_cnt = 0; m_ovf = 0; m_smp = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count in reset", count, '0);
    chk("R1 ovf in reset", {39'd0, ovf}, '0);
    up_valid = 1; up_hit = 1; #1;
    chk("R1 cleared tag value", {36'd0, up_tag}, '0);
    @(negedge clk); idle(); rst_n = 1;
    step("R1 after reset");

    // R3 / R5: ordinary stamping with bits 24,25 clear
    wcfg(mkcfg(4'h5, 4'h4, 0, 0));
    up_valid = 1; up_hit = 1; step("R3 stamp");
    up_valid = 1; up_hit = 0; step("R3 no hit");
    up_valid = 1; up_hit = 1; up_replay = 1; step("R4 replay disabled");
    retire(1, 4'h4, "R5 ordinary count");
    // R4 replay enabled
    wcfg(mkcfg(4'h9, 4'hF, 1, 0));
    up_valid = 1; up_hit = 1; up_replay = 1; step("R4 replay enabled");
    // R8 several matching bits
    retire(1, 4'hF, "R8 one per cycle");
    retire(1, 4'h9, "R8 one per cycle");
    // R7 bad path and invalid
    retire(0, 4'hF, "R7 bad path");
    rt_valid = 0; rt_good = 1; rt_tag = 4'hF; step("R7 invalid");
    // R9 combination
    wcfg(mkcfg(4'h3, 4'h3, 0, 0));
    up_valid = 1; up_hit = 1; step("R9 stamp 3");
    retire(1, 4'h1, "R9 first event");
    retire(1, 4'h2, "R9 second event");
    retire(1, 4'h4, "R9 third event excluded");
    // R10 load beats increment
    cnt_ld = 1; cnt_ld_val = 40'h12_3456_789A; rt_valid = 1; rt_good = 1; rt_tag = 4'h1;
    step("R10 load priority");
    // R11/R12 wrap with precise on
    wcfg(mkcfg(4'h3, 4'h3, 0, 1));
    cnt_ld = 1; cnt_ld_val = ONES - 1'b1; step("R10 preset");
    retire(1, 4'h1, "R11 reach all-ones");
    retire(1, 4'h2, "R12 wrap precise");
    step("R11 pulse ends");
    // wrap with precise off
    wcfg(mkcfg(4'h3, 4'h3, 0, 0));
    cnt_ld = 1; cnt_ld_val = ONES; step("R10 preset");
    retire(1, 4'h3, "R12 wrap no sample");
    step("R11 pulse ends");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom();
      if (r[3:0] == 0) begin
        cfg_we = 1;
        cfg_wdata = mkcfg(4'($urandom()), 4'($urandom()), r[4], r[5]);
      end
      up_valid = r[6]; up_hit = r[7]; up_replay = r[8];
      rt_valid = r[9] | r[10]; rt_good = r[11] | r[12]; rt_tag = 4'($urandom());
      if (r[19:13] == 0) begin
        cnt_ld = 1;
        cnt_ld_val = r[20] ? ONES - 40'($urandom_range(0, 3)) : {8'd0, 32'($urandom())};
      end
      step("R6 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule